// File: doc/BRIEF.md
# Braun Array Multiplier with Logarithmic-Depth Final Adder

This block multiplies two unsigned N-bit operands and returns the exact 2N-bit product. It works in three phases. An array of AND gates forms every partial-product bit. Rows of carry-save full adders then reduce those bits without any carry moving along a row. Finally, a carry-propagating adder merges the last row's sum and carry vectors into the upper half of the product.

That final adder is not a ripple chain. It is a Ladner-Fischer parallel prefix adder with three stages. First it forms generate and propagate bits from its inputs. A prefix tree then turns them into carries; the tree pairs even and odd positions, spreads group terms over doubling spans, and fills in the even positions last. Last, the sum bits are formed from the carries. Because of this, the depth of the final carry path grows with log2 N rather than with N.

The parameter `REG_OUT` selects whether the product is registered. When it is set, a register with a synchronous, active-high reset is added at the output. When it is clear, the block is purely combinational from operands to product.

Top module: `braun_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals the exact arithmetic product `a*b`, zero-extended to 2N bits.
- R2: Product bit 0 equals `a[0] & b[0]`.
- R3: The final prefix adder never produces a carry out of its top bit, so the 2N-bit product never overflows.
- R4: When either operand is zero, the product is zero.
- R5: When both operands are all ones, the product is 2^(2N) - 2^(N+1) + 1. For N=8 this is 0xFE01, and for N=16 it is 0xFFFE0001.
- R6: With `REG_OUT`=1, `prod` shows the product of the operands sampled at the previous rising clock edge. With `REG_OUT`=0, `prod` follows the operands with no clock.
- R7: With `REG_OUT`=1, a rising clock edge that sees `rst` high sets `prod` to zero, whatever the operands are.
- R8: The final prefix adder's N-bit sum, taken together with its carry out, equals the arithmetic sum of its two N-bit inputs.
- R9: When one operand is 1, the product equals the other operand, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1   | Clock for the optional output register |
| rst  | input  | 1   | Synchronous active-high reset of the output register |
| a    | input  | N   | Unsigned multiplicand |
| b    | input  | N   | Unsigned multiplier |
| prod | output | 2N  | Unsigned product |

## Verification
The combinational instance (N=4, `REG_OUT`=0) gives its product in the same time step as its inputs. Each of its 256 operand pairs is compared one time unit after the pair is applied. The registered instances (N=8 and N=16) take their operands on a falling edge and capture the product at the next rising edge. For each applied operand pair, the scoreboard pushes one expected entry on the falling edge. One time unit after the following rising edge, it pops that entry and compares it with the product, so every result is checked exactly one clock after its stimulus. Reset cycles push an expected value of zero in the same way.

// File: rtl/braun_pkg.sv
package braun_pkg;

   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // prefix operator: hi spans the more significant range, lo the range just below it
   function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

   // returns {carry, sum}
   function automatic logic [1:0] full_add(input logic x, input logic y, input logic z);
      return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
   endfunction

endpackage

// File: rtl/braun_pp_gen.sv
module braun_pp_gen #(
   parameter int N = 8
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [N*N-1:0] pp_flat
);
   // bit i*N+j holds a[j] & b[i]; its weight is 2^(i+j)
   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         assign pp_flat[i*N+j] = a[j] & b[i];
      end
   end
endmodule

// File: rtl/braun_csa_rows.sv
module braun_csa_rows
   import braun_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N*N-1:0] pp_flat,
   output logic [N-1:0]   lo_bits,
   output logic [N-1:0]   fin_x,
   output logic [N-1:0]   fin_y
);
   // srow[i][j] has weight 2^(i+j); crow[i][j] has weight 2^(i+j+1)
   logic [N-1:0] srow [N];
   logic [N-1:0] crow [N];

   assign srow[0] = pp_flat[N-1:0];
   assign crow[0] = '0;

   for (genvar i = 1; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_cell
         logic up_s;
         if (j == N-1) begin : g_edge
            assign up_s = 1'b0;
         end else begin : g_inner
            assign up_s = srow[i-1][j+1];
         end
         assign {crow[i][j], srow[i][j]} = full_add(pp_flat[i*N+j], up_s, crow[i-1][j]);
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_lo
      assign lo_bits[i] = srow[i][0];
   end

   // both vectors have weight 2^N at their bit 0
   assign fin_x = {1'b0, srow[N-1][N-1:1]};
   assign fin_y = crow[N-1];
endmodule

// File: rtl/braun_lf_adder.sv
module braun_lf_adder
   import braun_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum,
   output logic         cout
);
   localparam int NODD = W / 2;
   localparam int NLVL = (NODD > 1) ? $clog2(NODD) : 0;

   gp_t        pre  [W];
   gp_t        node [NLVL+1][W];
   gp_t        grp  [W];
   logic [W:0] cy;

   // pre-processing
   for (genvar i = 0; i < W; i++) begin : g_pre
      assign pre[i] = '{g: x[i] & y[i], p: x[i] ^ y[i]};
   end

   // odd positions absorb their even neighbour
   for (genvar i = 0; i < W; i++) begin : g_pair
      if ((i % 2) == 1) begin : g_odd
         assign node[0][i] = gp_merge(pre[i], pre[i-1]);
      end else begin : g_even
         assign node[0][i] = pre[i];
      end
   end

   // doubling spans over the odd positions
   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      for (genvar i = 0; i < W; i++) begin : g_pos
         if (((i % 2) == 1) && ((((i / 2) >> l) & 1) == 1)) begin : g_op
            localparam int SRC = 2 * ((((i / 2) >> l) << l) - 1) + 1;
            assign node[l+1][i] = gp_merge(node[l][i], node[l][SRC]);
         end else begin : g_pass
            assign node[l+1][i] = node[l][i];
         end
      end
   end

   // even positions fixed up from the odd prefix below
   for (genvar i = 0; i < W; i++) begin : g_fix
      if ((i % 2) == 1) begin : g_odd
         assign grp[i] = node[NLVL][i];
      end else if (i == 0) begin : g_first
         assign grp[i] = pre[0];
      end else begin : g_even
         assign grp[i] = gp_merge(pre[i], node[NLVL][i-1]);
      end
   end

   // post-processing
   assign cy[0] = 1'b0;
   for (genvar i = 0; i < W; i++) begin : g_post
      assign cy[i+1] = grp[i].g;
      assign sum[i]  = pre[i].p ^ cy[i];
   end
   assign cout = cy[W];
endmodule

// File: rtl/braun_mult.sv
module braun_mult #(
   parameter int N       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] prod
);
   localparam int PW = 2 * N;

   if (N < 2) begin : g_bad_width
      $error("braun_mult: N must be at least 2");
   end

   logic [N*N-1:0] pp_flat;
   logic [N-1:0]   lo_bits;
   logic [N-1:0]   fin_x;
   logic [N-1:0]   fin_y;
   logic [N-1:0]   fin_sum;
   logic           fin_cout;
   logic [PW-1:0]  prod_c;

   braun_pp_gen #(.N(N)) u_pp (
      .a       (a),
      .b       (b),
      .pp_flat (pp_flat)
   );

   braun_csa_rows #(.N(N)) u_csa (
      .pp_flat (pp_flat),
      .lo_bits (lo_bits),
      .fin_x   (fin_x),
      .fin_y   (fin_y)
   );

   braun_lf_adder #(.W(N)) u_fin (
      .x    (fin_x),
      .y    (fin_y),
      .sum  (fin_sum),
      .cout (fin_cout)
   );

   assign prod_c = {fin_sum, lo_bits};

   if (REG_OUT) begin : g_reg
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk) begin
         if (rst) prod_q <= '0;
         else     prod_q <= prod_c;
      end
      assign prod = prod_q;
   end else begin : g_comb
      assign prod = prod_c;
   end
endmodule

// File: rtl/braun_mult_chk.sv
module braun_mult_chk #(
   parameter int N       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic           clk,
   input logic           rst,
   input logic [N-1:0]   a,
   input logic [N-1:0]   b,
   input logic [2*N-1:0] prod,
   input logic [N-1:0]   fin_x,
   input logic [N-1:0]   fin_y,
   input logic [N-1:0]   fin_sum,
   input logic           fin_cout
);
   logic [2*N-1:0] ref_p;
   assign ref_p = {{N{1'b0}}, a} * {{N{1'b0}}, b};

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      fin_cout == 1'b0);

   assert_adder_exact_R8: assert property (@(posedge clk) disable iff (rst)
      {fin_cout, fin_sum} == ({1'b0, fin_x} + {1'b0, fin_y}));

   if (REG_OUT) begin : g_reg
      assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> prod == $past(ref_p));
      assert_lsb_R2: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> prod[0] == $past(a[0] & b[0]));
      assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && ($past(a) == '0 || $past(b) == '0)) |-> prod == '0);
   end else begin : g_comb
      assert_exact_R1: assert property (@(posedge clk) disable iff (rst)
         prod == ref_p);
      assert_lsb_R2: assert property (@(posedge clk) disable iff (rst)
         prod[0] == (a[0] & b[0]));
      assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
         (a == '0 || b == '0) |-> prod == '0);
   end
endmodule

bind braun_mult braun_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .a        (a),
   .b        (b),
   .prod     (prod),
   .fin_x    (fin_x),
   .fin_y    (fin_y),
   .fin_sum  (fin_sum),
   .fin_cout (fin_cout)
);

// File: tb/sim_braun_mult.sv
module sim_braun_mult;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  a8  = '0, b8  = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic [3:0]  a4  = '0, b4  = '0;
   logic [15:0] p8;
   logic [31:0] p16;
   logic [7:0]  p4;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [15:0] e8;
      logic [31:0] e16;
      string       req;
   } item_t;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   braun_mult #(.N(8),  .REG_OUT(1'b1)) u0 (.clk(clk), .rst(rst), .a(a8),  .b(b8),  .prod(p8));
   braun_mult #(.N(4),  .REG_OUT(1'b0)) u1 (.clk(clk), .rst(rst), .a(a4),  .b(b4),  .prod(p4));
   braun_mult #(.N(16), .REG_OUT(1'b1)) u2 (.clk(clk), .rst(rst), .a(a16), .b(b16), .prod(p16));

   task automatic drive(input logic [7:0] x8, input logic [7:0] y8,
                        input logic [15:0] x16, input logic [15:0] y16,
                        input logic r, input string req);
      item_t it;
      @(negedge clk);
      a8 = x8; b8 = y8; a16 = x16; b16 = y16; rst = r;
      it.e8  = r ? 16'h0 : ({8'h0, x8} * {8'h0, y8});
      it.e16 = r ? 32'h0 : ({16'h0, x16} * {16'h0, y16});
      it.req = req;
      sb.push_back(it);
   endtask

   // monitor: one result per clock, due one edge after its stimulus
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (p8 !== it.e8) begin
            errors++;
            $display("FAIL %s N=8: got %h expected %h", it.req, p8, it.e8);
         end
         checks++;
         if (p16 !== it.e16) begin
            errors++;
            $display("FAIL %s N=16: got %h expected %h", it.req, p16, it.e16);
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      // R1, R2, R4, R9: exhaustive on the combinational N=4 instance
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            logic [7:0] ex;
            a4 = 4'(x); b4 = 4'(y);
            #1;
            ex = 8'(x * y);
            checks++;
            if (p4 !== ex) begin
               errors++;
               $display("FAIL R1 N=4 %0d*%0d: got %h expected %h", x, y, p4, ex);
            end
         end
      end

      // R7: reset state
      drive(8'h5a, 8'hc3, 16'h1234, 16'hbeef, 1'b1, "R7");
      drive(8'hff, 8'hff, 16'hffff, 16'hffff, 1'b1, "R7");
      // R4: zero operands
      drive(8'h00, 8'h00, 16'h0000, 16'h0000, 1'b0, "R4");
      drive(8'h00, 8'hff, 16'h0000, 16'hffff, 1'b0, "R4");
      drive(8'hb7, 8'h00, 16'h9a31, 16'h0000, 1'b0, "R4");
      // R5, R3: all ones, largest product
      drive(8'hff, 8'hff, 16'hffff, 16'hffff, 1'b0, "R5");
      drive(8'hfe, 8'hff, 16'hfffe, 16'hffff, 1'b0, "R3");
      // R9: identity
      drive(8'h01, 8'hb5, 16'h0001, 16'hd00d, 1'b0, "R9");
      drive(8'he3, 8'h01, 16'h8001, 16'h0001, 1'b0, "R9");
      // R2: odd and even low bits
      drive(8'h81, 8'h7f, 16'h8001, 16'h7fff, 1'b0, "R2");
      drive(8'h80, 8'h81, 16'h8000, 16'h0003, 1'b0, "R2");
      // R1, R6: random back-to-back operands
      for (int k = 0; k < 400; k++) begin
         drive(8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 1'b0, "R6");
      end
      // R7: reset in mid-stream, then recovery
      drive(8'ha5, 8'h3c, 16'hcafe, 16'hf00d, 1'b1, "R7");
      drive(8'ha5, 8'h3c, 16'hcafe, 16'hf00d, 1'b0, "R1");
      drive(8'haa, 8'h55, 16'haaaa, 16'h5555, 1'b0, "R1");
      @(negedge clk);
      while (sb.size() > 0) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
   end
endmodule